// File: doc/BRIEF.md
# Pushbutton and Power-Fail Reset Sequencer

This block owns one open-drain, active-low reset line that is both read and driven. While nothing is going on it watches the line. When the line falls because someone pressed a button, the block pulls the line low itself for a debounce window. It then lets go and looks again. If the button is still held, the block waits for the line to rise and then issues a reset pulse of fixed length. A short press that has already ended when the debounce window closes counts as a glitch and produces no pulse.

A power-fail input takes precedence over everything else. While it is high the line is held low. When it drops, the line stays low for a recovery window, but only if the oscillator is running. With the oscillator stopped, the line is let go at once.

All windows are counted in pulses of a clock-enable input, so the block can run on a fast clock and still produce long intervals. Holding the line low changes nothing else in the block; it only drives the pin.

Top module: `pbreset_seq`

## Requirements
- R1: After reset the block does not drive the line (`drive_low` = 0), and it stays idle while the line sits high.
- R2: A falling edge on the line, seen through a two-flop synchronizer, makes the block drive the line low for DEBOUNCE_TICKS clock-enable pulses.
- R3: After the debounce window the block stops driving for three clock cycles of settling. If the line is then still low, the block keeps waiting, without driving, until the line goes high.
- R4: When the line goes high after a confirmed press, the block drives it low for PULSE_TICKS clock-enable pulses and then releases it.
- R5: If the line is already high when the settling time ends, the block goes back to idle and issues no reset pulse.
- R6: While `pwr_fail` is 1, `drive_low` is 1. It rises in the same cycle that `pwr_fail` rises.
- R7: When `pwr_fail` falls while `osc_run` is 1, the line stays driven for RECOVER_TICKS clock-enable pulses.
- R8: When `pwr_fail` falls while `osc_run` is 0, the line is released on the next clock edge.
- R9: Raising `pwr_fail` aborts any pushbutton sequence in progress. After recovery, a button that is still held produces no reset pulse, either while it stays held or when it is let go.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| tick | input | 1 | Clock enable that advances the interval timers |
| line_in | input | 1 | Level sensed on the reset pin |
| pwr_fail | input | 1 | Supply-low indication, 1 means power failing |
| osc_run | input | 1 | 1 when the oscillator is running |
| drive_low | output | 1 | 1 pulls the open-drain reset pin low |

## Verification
The bench models the pin as a pull-up shared by the button and `drive_low`. This means the block sees its own drive, just as it would on a real board.

- **Long and short presses.** The bench presses and holds the button, and it also presses it briefly. A design that sampled the pin before its own drive had settled through the synchronizer would mistake its own pull-down for a held button, and a glitch would then produce a reset pulse.
- **Power fail during a press.** Power fails in the middle of a debounce window while the button stays held. A design that did not abort the press would resume after recovery and fire a pulse on release.
- **Recovery with and without the oscillator.** Power returns once with the oscillator running and once with it stopped. A design with the skip logic inverted would either hold the pin during the release window that should be immediate, or cut the recovery window short.

// File: rtl/pbreset_seq.sv
module pbreset_seq #(
  parameter int DEBOUNCE_TICKS = 5,
  parameter int PULSE_TICKS    = 8,
  parameter int RECOVER_TICKS  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line_in,
  input  logic pwr_fail,
  input  logic osc_run,
  output logic drive_low
);
  localparam int SETTLE = 3;
  localparam int MAXA = (DEBOUNCE_TICKS > PULSE_TICKS) ? DEBOUNCE_TICKS : PULSE_TICKS;
  localparam int MAXB = (MAXA > RECOVER_TICKS) ? MAXA : RECOVER_TICKS;
  localparam int MAXT = (MAXB > SETTLE) ? MAXB : SETTLE;
  localparam int CW = $clog2(MAXT + 1);

  typedef enum logic [2:0] {IDLE, DEBOUNCE, CHECK, WAIT_REL, PULSE, PFAIL, RECOVER} st_t;
  st_t st;
  logic [CW-1:0] cnt;
  logic s0, s1, sq;

  wire fall   = sq & ~s1;
  wire deb_dn = tick && cnt == CW'(DEBOUNCE_TICKS - 1);
  wire pul_dn = tick && cnt == CW'(PULSE_TICKS - 1);
  wire rec_dn = tick && cnt == CW'(RECOVER_TICKS - 1);
  wire chk_dn = cnt == CW'(SETTLE - 1);

  assign drive_low = pwr_fail || st == DEBOUNCE || st == PULSE || st == PFAIL || st == RECOVER;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0 <= 1'b1;
      s1 <= 1'b1;
      sq <= 1'b1;
    end else begin
      s0 <= line_in;
      s1 <= s0;
      sq <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= IDLE;
      cnt <= '0;
    end else if (pwr_fail) begin
      st  <= PFAIL;
      cnt <= '0;
    end else begin
      unique case (st)
        IDLE: if (fall) begin st <= DEBOUNCE; cnt <= '0; end
        DEBOUNCE:
          if (deb_dn) begin st <= CHECK; cnt <= '0; end
          else if (tick) cnt <= cnt + 1'b1;
        CHECK:
          if (chk_dn) begin st <= s1 ? IDLE : WAIT_REL; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        WAIT_REL: if (s1) begin st <= PULSE; cnt <= '0; end
        PULSE:
          if (pul_dn) begin st <= IDLE; cnt <= '0; end
          else if (tick) cnt <= cnt + 1'b1;
        PFAIL: begin
          st  <= osc_run ? RECOVER : IDLE;
          cnt <= '0;
        end
        RECOVER:
          if (rec_dn) begin st <= IDLE; cnt <= '0; end
          else if (tick) cnt <= cnt + 1'b1;
        default: begin st <= IDLE; cnt <= '0; end
      endcase
    end
  end

  assert_press_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE && fall && !pwr_fail) |=> drive_low);
  assert_release_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == WAIT_REL && s1 && !pwr_fail) |=> drive_low);
  assert_pf_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> drive_low);
  assert_recover_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pwr_fail) && osc_run) |=> drive_low);
  assert_skip_recover_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pwr_fail) && !osc_run) |=> (!drive_low || pwr_fail));
endmodule

// File: tb/sim_pbreset_seq.sv
module sim_pbreset_seq;
  localparam int DEB = 5, PUL = 6, REC = 7;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, pwr_fail = 1'b0, osc_run = 1'b1, btn = 1'b0;
  logic drive_low;
  wire line_in = !(drive_low || btn);
  int checks = 0, fails = 0, cyc = 0, tdiv = 0;

  always #5 clk = ~clk;

  pbreset_seq #(.DEBOUNCE_TICKS(DEB), .PULSE_TICKS(PUL), .RECOVER_TICKS(REC)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line_in(line_in),
    .pwr_fail(pwr_fail), .osc_run(osc_run), .drive_low(drive_low));

  // reference model: phases 0 idle,1 debounce,2 settle,3 wait release,4 pulse,5 power fail,6 recovery
  int ph = 0, mc = 0;
  bit hist[3] = '{1, 1, 1};
  function automatic bit mdrive();
    return pwr_fail || ph == 1 || ph == 4 || ph == 5 || ph == 6;
  endfunction
  function automatic string req_of();
    case (ph)
      0: return "R1/R5/R9";
      1: return "R2";
      2, 3: return "R3";
      4: return "R4";
      5: return "R6";
      default: return "R7";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; mc = 0; hist = '{1, 1, 1};
    end else begin
      bit pin, cur, old;
      pin = !(mdrive() || btn);
      cur = hist[1];
      old = hist[2];
      hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = pin;
      if (pwr_fail) begin ph = 5; mc = 0; end
      else case (ph)
        0: if (old && !cur) begin ph = 1; mc = 0; end
        1: if (tick) begin mc++; if (mc == DEB) begin ph = 2; mc = 0; end end
        2: begin mc++; if (mc == 3) begin ph = cur ? 0 : 3; mc = 0; end end
        3: if (cur) begin ph = 4; mc = 0; end
        4: if (tick) begin mc++; if (mc == PUL) begin ph = 0; mc = 0; end end
        5: begin ph = osc_run ? 6 : 0; mc = 0; end
        default: if (tick) begin mc++; if (mc == REC) begin ph = 0; mc = 0; end end
      endcase
    end
  end

  task automatic check(input string req, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: drive_low=%0b expected %0b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    tdiv = (tdiv + 1) % 4;
    tick <= (tdiv == 0);
    if (rst_n) check(req_of(), drive_low, mdrive());
    if (cyc > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected below 20000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic wn(input int n);
    repeat (n) @(negedge clk);
  endtask

  int seen;
  initial begin
    wn(5);
    check("R1 reset", drive_low, 1'b0);
    rst_n = 1'b1;
    wn(20);
    check("R1 idle", drive_low, 1'b0);
    // long press and release: debounce, wait, pulse (R2 R3 R4)
    btn = 1'b1; wn(70); btn = 1'b0; wn(80);
    // glitch shorter than debounce: no pulse (R5)
    btn = 1'b1; wn(3); btn = 1'b0;
    seen = 0;
    wn(30);
    repeat (60) begin @(negedge clk); if (drive_low) seen++; end
    checks++;
    if (seen != 0) begin fails++; $display("FAIL R5: %0d driven cycles after glitch, expected 0", seen); end
    // power fail mid-debounce with button held, oscillator running (R6 R7 R9)
    btn = 1'b1; wn(10);
    pwr_fail = 1'b1; #1 check("R6 immediate", drive_low, 1'b1);
    wn(20); pwr_fail = 1'b0; wn(1);
    check("R7 recovery", drive_low, 1'b1);
    wn(60);
    btn = 1'b0;
    seen = 0;
    repeat (80) begin @(negedge clk); if (drive_low) seen++; end
    checks++;
    if (seen != 0) begin fails++; $display("FAIL R9: %0d driven cycles after release, expected 0", seen); end
    // power fail with oscillator stopped (R8)
    osc_run = 1'b0; pwr_fail = 1'b1; wn(10);
    pwr_fail = 1'b0; wn(1);
    check("R8 skip", drive_low, 1'b0);
    wn(20); osc_run = 1'b1;
    // second press with different hold length
    btn = 1'b1; wn(33); btn = 1'b0; wn(60);
    // power fail during the reset pulse
    btn = 1'b1; wn(45); btn = 1'b0; wn(8);
    pwr_fail = 1'b1; wn(6); pwr_fail = 1'b0; wn(80);
    check("R1 final", drive_low, 1'b0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule